// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is the target side of a two-wire (I2C-style) serial configuration port that fronts a small byte-wide register bank. Both bus lines are brought into the system clock domain through two-flop synchronisers. START, repeated START and STOP are then detected from edges of the synchronised lines. Incoming bits are sampled on rising SCL. The block changes its own data-line drive only after SCL has been seen low. The block never drives the line high. It reports a pull-down request on `sda_oe`, and the pad turns that into an open-drain output.

A transaction begins with an 8-bit device byte made of a 7-bit address and a read/write flag. When `addr_sel` is low the block answers to 0x20 for writes and 0x21 for reads. When `addr_sel` is high it answers to 0x30 and 0x31. A write transfer carries a 16-bit register pointer as two bytes, high byte first, followed by any number of data bytes. A read transfer returns bytes starting at the stored pointer. The pointer is kept between transactions and advances by one after every data byte, so a read sent without an address phase continues from wherever the last access stopped. Register index 0 holds a soft-reset bit. Writing a 1 to it clears the bank and raises a one-cycle pulse. That bit always reads back as 0.

The controller has these states. ST_IDLE is the bus-free state. ST_DEVADR receives the device byte. ST_DEVACK acknowledges it. ST_PTRHI and ST_ACKHI take and acknowledge the pointer high byte. ST_PTRLO and ST_ACKLO do the same for the low byte. ST_WRDAT and ST_ACKWR take and acknowledge write data. ST_RDDAT shifts read data out. ST_RDACK samples the master's acknowledge. ST_SKIP waits out a transfer that is not addressed to the block or has been ended.

The transitions are as follows:
- STOP leads from any state to ST_IDLE.
- START, including a repeated START, leads from any state to ST_DEVADR.
- ST_DEVADR leads to ST_DEVACK on an address match and to ST_SKIP otherwise.
- ST_DEVACK leads to ST_RDDAT when the read flag is set and to ST_PTRHI when it is clear.
- The pointer path runs ST_PTRHI, ST_ACKHI, ST_PTRLO, ST_ACKLO and then ST_WRDAT. ST_WRDAT and ST_ACKWR then alternate.
- ST_RDDAT leads to ST_RDACK. ST_RDACK returns to ST_RDDAT when the master acknowledges and goes to ST_SKIP when it does not.

Top module: `twowire_regslave`

## Requirements
- R1: With `addr_sel` low, device bytes 0x20 and 0x21 are acknowledged, and any other device byte, 0x30 included, is left unacknowledged and the transfer is ignored.
- R2: With `addr_sel` high, device bytes 0x30 and 0x31 are acknowledged, and 0x20 is not.
- R3: After a write device byte, the next two bytes form the 16-bit register pointer, high byte first. Each of the two bytes is acknowledged.
- R4: A data byte that follows the pointer is acknowledged and stored at the register the pointer selects.
- R5: After each written data byte the pointer advances by one, so consecutive data bytes fill consecutive registers.
- R6: In a read, bytes are driven MSB first. The pointer advances after each byte, so consecutive bytes come from consecutive registers.
- R7: A read with no preceding pointer phase returns data from the pointer left by the previous access. The pointer is 0 after reset.
- R8: When the master answers a read byte with NACK, the block stops driving. After STOP the data line stays released while the bus is idle.
- R9: Writing a byte with bit 0 set to register 0 clears every register to 0x00 and raises `soft_rst_pulse` for exactly one clock. Bit 0 of register 0 always reads as 0.
- R10: A repeated START returns the block to device-address matching and leaves the pointer unchanged.
- R11: `sda_oe` changes only while the synchronised SCL is low.
- R12: Pointer values at or above the bank depth (8) read as 0x00. Writes to such values are acknowledged but change no register and trigger no soft reset.
- R13: After reset `sda_oe` and `soft_rst_pulse` are low and every register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad (wired-AND value) |
| addr_sel | input | 1 | Selects the alternate device address when high |
| sda_oe | output | 1 | High to pull the data line low |
| soft_rst_pulse | output | 1 | One-cycle pulse on a soft-reset write |

## Verification
The hardest state to reach from the ports is a read that continues from a pointer the block kept from an earlier, unrelated transaction. Only the pointer's effect on returned data can show it. The stimulus builds that case in stages. A random read of one byte leaves the pointer part-way into the bank, and a later read without an address phase must continue from that point. A random read with a repeated START between the pointer phase and the read phase shows that the restart kept the pointer. Soft reset is checked by reading back the whole bank and by counting pulse cycles.

// File: rtl/twr_pkg.sv
package twr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADR,
        ST_DEVACK,
        ST_PTRHI,
        ST_ACKHI,
        ST_PTRLO,
        ST_ACKLO,
        ST_WRDAT,
        ST_ACKWR,
        ST_RDDAT,
        ST_RDACK,
        ST_SKIP
    } twr_state_e;

    localparam int TWR_BYTE_BITS = 8;
    localparam int TWR_PTR_BITS  = 16;

endpackage

// File: rtl/twr_sync.sv
module twr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_q,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_seen,
    output logic stop_seen
);

    logic [1:0] raw;
    logic [1:0] synced;
    logic [1:0] prev;

    assign raw = {sda_raw, scl_raw};

    for (genvar g = 0; g < 2; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 2'b11;
        else        prev <= synced;
    end

    assign scl_q      = synced[0];
    assign sda_q      = synced[1];
    assign scl_rise   = synced[0] & ~prev[0];
    assign scl_fall   = ~synced[0] & prev[0];
    assign start_seen = synced[0] & prev[0] & prev[1] & ~synced[1];
    assign stop_seen  = synced[0] & prev[0] & ~prev[1] & synced[1];

endmodule

// File: rtl/twr_regbank.sv
module twr_regbank #(
    parameter int DEPTH   = 8,
    parameter int DW      = 8,
    parameter int AW      = 16,
    parameter int RST_IDX = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          soft_rst
);

    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0] mem [DEPTH];
    logic          hit;
    logic [IW-1:0] idx;
    logic          do_srst;

    assign hit     = (addr < AW'(DEPTH));
    assign idx     = addr[IW-1:0];
    assign do_srst = wr_en && hit && (idx == IW'(RST_IDX)) && wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (do_srst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en && hit) begin
            mem[idx] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) soft_rst <= 1'b0;
        else        soft_rst <= do_srst;
    end

    always_comb begin
        rdata = '0;
        if (hit) begin
            rdata = mem[idx];
            if (idx == IW'(RST_IDX)) rdata[0] = 1'b0;
        end
    end

endmodule

// File: rtl/twowire_regslave.sv
module twowire_regslave #(
    parameter int         DEPTH    = 8,
    parameter logic [6:0] ADDR_PRI = 7'h10,
    parameter logic [6:0] ADDR_ALT = 7'h18,
    parameter int         SYNC_LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic addr_sel,
    output logic sda_oe,
    output logic soft_rst_pulse
);
    import twr_pkg::*;

    localparam int BW = TWR_BYTE_BITS;
    localparam int PW = TWR_PTR_BITS;

    logic scl_q, sda_q, scl_rise, scl_fall, start_seen, stop_seen;
    twr_state_e state, nxt;
    logic [3:0]    cnt;
    logic [BW-1:0] shreg;
    logic [BW-1:0] ptr_hi;
    logic [PW-1:0] ptr;
    logic          nack_seen;
    logic          byte_done;
    logic          addr_hit;
    logic [6:0]    my_addr;
    logic          wr_fire;
    logic [BW-1:0] rd_data;

    twr_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_raw(scl_in), .sda_raw(sda_in),
        .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_seen(start_seen), .stop_seen(stop_seen)
    );

    assign my_addr   = addr_sel ? ADDR_ALT : ADDR_PRI;
    assign byte_done = (cnt == 4'd8);
    assign addr_hit  = (shreg[7:1] == my_addr);
    assign wr_fire   = (state == ST_WRDAT) && scl_fall && byte_done && !start_seen && !stop_seen;

    twr_regbank #(.DEPTH(DEPTH), .DW(BW), .AW(PW), .RST_IDX(0)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_fire), .addr(ptr),
        .wdata(shreg), .rdata(rd_data), .soft_rst(soft_rst_pulse)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        if (stop_seen) begin
            nxt = ST_IDLE;
        end else if (start_seen) begin
            nxt = ST_DEVADR;
        end else begin
            unique case (state)
                ST_IDLE, ST_SKIP: nxt = state;
                ST_DEVADR: if (scl_fall && byte_done) nxt = addr_hit ? ST_DEVACK : ST_SKIP;
                ST_DEVACK: if (scl_fall) nxt = shreg[0] ? ST_RDDAT : ST_PTRHI;
                ST_PTRHI:  if (scl_fall && byte_done) nxt = ST_ACKHI;
                ST_ACKHI:  if (scl_fall) nxt = ST_PTRLO;
                ST_PTRLO:  if (scl_fall && byte_done) nxt = ST_ACKLO;
                ST_ACKLO:  if (scl_fall) nxt = ST_WRDAT;
                ST_WRDAT:  if (scl_fall && byte_done) nxt = ST_ACKWR;
                ST_ACKWR:  if (scl_fall) nxt = ST_WRDAT;
                ST_RDDAT:  if (scl_fall && byte_done) nxt = ST_RDACK;
                ST_RDACK:  if (scl_fall) nxt = nack_seen ? ST_SKIP : ST_RDDAT;
            endcase
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            shreg     <= '0;
            ptr_hi    <= '0;
            ptr       <= '0;
            nack_seen <= 1'b0;
            sda_oe    <= 1'b0;
        end else if (stop_seen) begin
            sda_oe <= 1'b0;
        end else if (start_seen) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
        end else begin
            unique case (state)
                ST_IDLE, ST_SKIP: sda_oe <= 1'b0;
                ST_DEVADR, ST_PTRHI, ST_PTRLO, ST_WRDAT: begin
                    if (scl_rise) begin
                        shreg <= {shreg[BW-2:0], sda_q};
                        cnt   <= cnt + 4'd1;
                    end else if (scl_fall && byte_done) begin
                        sda_oe <= (state != ST_DEVADR) || addr_hit;
                        if (state == ST_PTRHI) ptr_hi <= shreg;
                        if (state == ST_PTRLO) ptr    <= {ptr_hi, shreg};
                        if (state == ST_WRDAT) ptr    <= ptr + 1'b1;
                    end
                end
                ST_DEVACK, ST_ACKHI, ST_ACKLO, ST_ACKWR: begin
                    if (scl_fall) begin
                        cnt <= '0;
                        if (state == ST_DEVACK && shreg[0]) begin
                            shreg  <= rd_data;
                            sda_oe <= ~rd_data[BW-1];
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                end
                ST_RDDAT: begin
                    if (scl_rise) begin
                        cnt <= cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (byte_done) begin
                            sda_oe <= 1'b0;
                            ptr    <= ptr + 1'b1;
                        end else begin
                            shreg  <= {shreg[BW-2:0], 1'b0};
                            sda_oe <= ~shreg[BW-2];
                        end
                    end
                end
                ST_RDACK: begin
                    if (scl_rise) begin
                        nack_seen <= sda_q;
                    end else if (scl_fall) begin
                        cnt <= '0;
                        if (!nack_seen) begin
                            shreg  <= rd_data;
                            sda_oe <= ~rd_data[BW-1];
                        end
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/twr_checks.sv
module twr_checks (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 scl_q,
    input logic                 sda_oe,
    input logic                 soft_rst_pulse,
    input logic                 start_seen,
    input logic                 stop_seen,
    input logic [15:0]          ptr,
    input twr_pkg::twr_state_e  state
);
    import twr_pkg::*;

    p_oe_moves_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_q);

    p_idle_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);

    p_stop_releases_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_seen |=> !sda_oe);

    p_srst_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_pulse |=> !soft_rst_pulse);

    p_restart_keeps_ptr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_seen |=> $stable(ptr));

endmodule

bind twowire_regslave twr_checks u_chk (
    .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .sda_oe(sda_oe),
    .soft_rst_pulse(soft_rst_pulse), .start_seen(start_seen),
    .stop_seen(stop_seen), .ptr(ptr), .state(state)
);

// File: tb/twowire_regslave_test.sv
`timescale 1ns/1ps
module twowire_regslave_test;

    localparam int H = 8;
    localparam int NREG = 8;

    typedef logic [7:0] bq_t[$];

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic addr_sel = 1'b0;
    logic sda_oe;
    logic soft_rst_pulse;
    logic sda_line;

    assign sda_line = sda_m & ~sda_oe;

    twowire_regslave uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .addr_sel(addr_sel), .sda_oe(sda_oe), .soft_rst_pulse(soft_rst_pulse)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] mregs [NREG];
    int  mptr = 0;
    bit  bus_idle = 1'b1;
    bit  mon_en = 1'b0;
    logic prev_oe = 1'b0;
    int  pulse_cycles = 0;
    int  pulse_events = 0;
    logic prev_pulse = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock comparison against the bus model
    always @(negedge clk) begin
        if (mon_en) begin
            if (bus_idle) check(sda_oe == 1'b0, "R8 idle release", int'(sda_oe), 0);
            if (sda_oe != prev_oe) check(scl_m == 1'b0, "R11 oe moves with scl low", int'(scl_m), 0);
        end
        prev_oe = sda_oe;
    end

    always @(posedge clk) begin
        if (soft_rst_pulse) pulse_cycles++;
        if (soft_rst_pulse && !prev_pulse) pulse_events++;
        prev_pulse <= soft_rst_pulse;
    end

    task automatic hw();
        repeat (H) @(negedge clk);
    endtask

    task automatic bus_start();
        bus_idle = 1'b0;
        sda_m = 1'b1; hw();
        scl_m = 1'b1; hw();
        sda_m = 1'b0; hw();
        scl_m = 1'b0; hw();
    endtask

    task automatic bus_stop();
        repeat (2) @(negedge clk);
        sda_m = 1'b0; hw();
        scl_m = 1'b1; hw();
        sda_m = 1'b1; hw();
        hw();
        bus_idle = 1'b1;
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            repeat (2) @(negedge clk);
            sda_m = b[i]; hw();
            scl_m = 1'b1; hw();
            scl_m = 1'b0;
        end
        repeat (2) @(negedge clk);
        sda_m = 1'b1; hw();
        scl_m = 1'b1;
        repeat (H/2) @(negedge clk);
        ack = !sda_line;
        repeat (H/2) @(negedge clk);
        scl_m = 1'b0;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hw();
            scl_m = 1'b1;
            repeat (H/2) @(negedge clk);
            b[i] = sda_line;
            repeat (H/2) @(negedge clk);
            scl_m = 1'b0;
        end
        repeat (2) @(negedge clk);
        sda_m = give_ack ? 1'b0 : 1'b1; hw();
        scl_m = 1'b1; hw();
        scl_m = 1'b0;
        repeat (2) @(negedge clk);
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] mread(input int p);
        if (p < NREG) return mregs[p];
        return 8'h00;
    endfunction

    task automatic mwrite(input int p, input logic [7:0] d);
        if (p < NREG) begin
            if (p == 0 && d[0]) begin
                for (int i = 0; i < NREG; i++) mregs[i] = 8'h00;
            end else begin
                mregs[p] = d;
            end
        end
    endtask

    // pointer phase (R3); leaves the bus inside the transfer
    task automatic ptr_phase(input logic [7:0] dev, input int p);
        bit a;
        bus_start();
        send_byte(dev, a);
        check(a, "R1/R2 write device ack", int'(a), 1);
        send_byte(8'(p >> 8), a);
        check(a, "R3 pointer high ack", int'(a), 1);
        send_byte(8'(p), a);
        check(a, "R3 pointer low ack", int'(a), 1);
        mptr = p;
    endtask

    task automatic wr_seq(input logic [7:0] dev, input int p, input bq_t d);
        bit a;
        ptr_phase(dev, p);
        foreach (d[k]) begin
            send_byte(d[k], a);
            check(a, "R4 data ack", int'(a), 1);
            mwrite(mptr, d[k]);
            mptr++;
        end
        bus_stop();
    endtask

    task automatic rd_body(input logic [7:0] dev, input int n, input string req);
        bit a;
        logic [7:0] got;
        send_byte(dev, a);
        check(a, "R1/R2 read device ack", int'(a), 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, got);
            check(got == mread(mptr), req, int'(got), int'(mread(mptr)));
            mptr++;
        end
        bus_stop();
        check(sda_oe == 1'b0, "R8 released after NACK and STOP", int'(sda_oe), 0);
    endtask

    task automatic rd_cur(input logic [7:0] dev, input int n, input string req);
        bus_start();
        rd_body(dev, n, req);
    endtask

    task automatic rd_rand(input logic [7:0] wdev, input logic [7:0] rdev, input int p, input int n, input string req);
        ptr_phase(wdev, p);
        bus_start();   // repeated START, pointer must survive (R10)
        rd_body(rdev, n, req);
    endtask

    task automatic expect_nack(input logic [7:0] dev, input string req);
        bit a;
        bus_start();
        send_byte(dev, a);
        check(!a, req, int'(a), 0);
        hw();
        check(sda_oe == 1'b0, req, int'(sda_oe), 0);
        bus_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int pe;
        for (int i = 0; i < NREG; i++) mregs[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R13 reset state
        check(sda_oe == 1'b0, "R13 sda_oe after reset", int'(sda_oe), 0);
        check(soft_rst_pulse == 1'b0, "R13 pulse after reset", int'(soft_rst_pulse), 0);
        mon_en = 1'b1;
        // R7/R13: pointer starts at 0, reg reads 0
        rd_cur(8'h21, 1, "R13 R7 first current read");

        // R3 R4 R5 sequential write
        wr_seq(8'h20, 3, '{8'h5A, 8'h66});
        wr_seq(8'h20, 5, '{8'hC3});
        // R6 R10 sequential random read with repeated START
        rd_rand(8'h20, 8'h21, 3, 3, "R6 R10 sequential read");
        // R7 current-location read continues from kept pointer
        rd_rand(8'h20, 8'h21, 3, 1, "R6 single random read");
        rd_cur(8'h21, 2, "R7 current-location read");

        // R1 address filtering
        expect_nack(8'h30, "R1 alternate ignored when sel low");
        expect_nack(8'h44, "R1 foreign address ignored");
        // R2 alternate address
        addr_sel = 1'b1;
        repeat (4) @(negedge clk);
        expect_nack(8'h20, "R2 primary ignored when sel high");
        wr_seq(8'h30, 7, '{8'h42});
        rd_cur(8'h31, 1, "R12 R2 read past end gives zero");
        rd_rand(8'h30, 8'h31, 7, 1, "R2 alternate read back");
        addr_sel = 1'b0;
        repeat (4) @(negedge clk);

        // R12 out-of-range write has no effect
        wr_seq(8'h20, 0, '{8'hF0});
        pe = pulse_events;
        wr_seq(8'h20, 16'h0100, '{8'hFF});
        rd_rand(8'h20, 8'h21, 16'h0100, 1, "R12 out-of-range read");
        rd_rand(8'h20, 8'h21, 0, 1, "R12 reg0 untouched by alias");
        check(pulse_events == pe, "R12 no soft reset from alias", pulse_events, pe);

        // R9 soft reset
        wr_seq(8'h20, 2, '{8'h11, 8'h22});
        rd_rand(8'h20, 8'h21, 0, 5, "R9 bank before soft reset");
        pe = pulse_events;
        wr_seq(8'h20, 0, '{8'h81});
        check(pulse_events == pe + 1, "R9 one soft reset event", pulse_events, pe + 1);
        check(pulse_cycles == pulse_events, "R9 pulse one cycle wide", pulse_cycles, pulse_events);
        rd_rand(8'h20, 8'h21, 0, 8, "R9 bank cleared");
        wr_seq(8'h20, 0, '{8'h80});
        rd_rand(8'h20, 8'h21, 0, 1, "R9 bit0 reads zero");

        repeat (20) @(negedge clk);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule